// File: doc/BRIEF.md
# Serial Receiver with Selectable Word Formats

This block takes an asynchronous serial line and turns it into bytes for a host. The host supplies a receive baud clock that is unrelated to the system clock. Both that clock and the serial line pass through two-flop synchronisers. A rising edge of the synchronised baud clock is the only event that advances the receiver. A 3-bit format code selects the frame shape: data width, parity kind and stop-bit count. A 2-bit divide code selects one, 16 or 64 baud-clock periods per bit.

Each received byte comes out on a valid/data pair with three error flags. The flags report a bad stop bit, a parity mismatch and a character lost to overrun. The serial line cannot be paused, so the block applies no back-pressure. `rx_ready` works as a read strobe: a cycle with it high retires the held byte and clears the flags. If a new character completes while `rx_valid` is still high and `rx_ready` is low, the new byte replaces the old one and the overrun flag is raised.

Top module: `uart_wordfmt_rx`

## Requirements
- R1: While `rst` is high, or while `div_sel` is 11, the receiver is idle and `rx_valid`, `rx_data` and all three error flags are zero on the following cycle.
- R2: `fmt_sel` selects the frame as follows: 0→7 data bits, even parity, 2 stop; 1→7 data bits, odd parity, 2 stop; 2→7 data bits, even parity, 1 stop; 3→7 data bits, odd parity, 1 stop; 4→8 data bits, no parity, 2 stop; 5→8 data bits, no parity, 1 stop; 6→8 data bits, even parity, 1 stop; 7→8 data bits, odd parity, 1 stop.
- R3: A sample event is a rising edge of `rx_clk` seen after synchronisation. `div_sel` 00 samples one bit per event. Code 01 samples one bit every 16 events and code 10 one bit every 64 events. The state does not move between events.
- R4: With code 00, a low sample while idle is a start bit. With code 01 or 10, a low sample while idle arms a start. The line is checked again after half a bit (8 or 32 events). If the line is high then, the character is dropped without output.
- R5: Data bits arrive least significant first. For 7-bit formats, `rx_data[7]` is zero.
- R6: `err_parity` is set with a character when the count of ones over the data bits and the parity bit is odd under even parity, or even under odd parity. It is never set for the parity-less formats.
- R7: `err_frame` is set with a character when any of its stop-bit samples is low.
- R8: When a character completes while `rx_valid` is high and `rx_ready` is low, `err_overrun` is set and `rx_data` takes the new byte. Otherwise a completing character leaves `err_overrun` low.
- R9: A cycle with `rx_ready` high and no character completing clears `rx_valid` and the three flags on the next cycle. If a character completes in the same cycle, the new character is loaded instead.
- R10: The outputs update on the cycle after the system-clock edge at which the final stop bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 3 | Frame format code |
| div_sel | input | 2 | Baud divide code (11 holds the receiver idle) |
| rx_clk | input | 1 | Receive baud clock, asynchronous |
| rx_din | input | 1 | Serial data line, asynchronous |
| rx_ready | input | 1 | Host read strobe |
| rx_valid | output | 1 | A received byte is held |
| rx_data | output | 8 | Received byte |
| err_frame | output | 1 | Stop-bit error for the held byte |
| err_parity | output | 1 | Parity error for the held byte |
| err_overrun | output | 1 | An unread byte was overwritten |

## Verification
All eight format codes are sent in x1 mode with different byte values. This separates the data-width, parity-kind and stop-count decoding, and an all-ones byte in a 7-bit format shows that bit 7 is cleared. Frames in x16 and x64 mode test the mid-bit counting. A short low glitch in x16 mode checks that a start the line does not hold is dropped. Frames with an inverted parity bit or a low stop bit show that each flag is raised on its own. Two frames sent without a read test overrun, and a read cycle and a switch to divide code 11 test clearing. A behavioural model predicts every output on every cycle, which pins down the completion timing.

// File: rtl/uart_wordfmt_pkg.sv
package uart_wordfmt_pkg;

  typedef struct packed {
    logic seven;     // 7 data bits when set
    logic par_en;    // parity bit present
    logic odd;       // odd parity when set
    logic two_stop;  // two stop bits when set
  } frame_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  localparam logic [1:0] DIV_X1   = 2'b00;
  localparam logic [1:0] DIV_MID  = 2'b01;
  localparam logic [1:0] DIV_HI   = 2'b10;
  localparam logic [1:0] DIV_HOLD = 2'b11;

  function automatic frame_cfg_t decode_frame(input logic [2:0] code);
    frame_cfg_t c;
    c.seven    = ~code[2];
    c.par_en   = ~(code == 3'd4 || code == 3'd5);
    c.odd      = code[0];
    c.two_stop = (code == 3'd0) || (code == 3'd1) || (code == 3'd4);
    return c;
  endfunction

endpackage

// File: rtl/uwr_sync.sv
module uwr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int SW = STAGES * W;

  logic [SW-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[SW-W-1:0], d};
      end
    end
  endgenerate

  assign q = chain[SW-1 -: W];
endmodule

// File: rtl/uwr_edge.sv
module uwr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

  // R3: two sample events are never adjacent
  a_r3_event_spacing: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/uwr_deframe.sv
module uwr_deframe
  import uart_wordfmt_pkg::*;
#(
  parameter int MID_DIV = 16,
  parameter int HI_DIV  = 64
) (
  input  logic       clk,
  input  logic       hold,
  input  logic       tick,
  input  logic       rxd,
  input  logic [2:0] fmt_sel,
  input  logic [1:0] div_sel,
  output logic       done,
  output logic [7:0] byte_o,
  output logic       fe_o,
  output logic       pe_o
);
  localparam int CNT_W = (HI_DIV > MID_DIV) ? $clog2(HI_DIV) : $clog2(MID_DIV);

  frame_cfg_t       cfg;
  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] div_m1;
  logic [CNT_W-1:0] half_m1;
  logic [2:0]       idx;
  logic [2:0]       last_idx;
  logic [7:0]       shr;
  logic             par_acc;
  logic             fe_acc;
  logic             stop_pend;
  logic             at_end;
  logic             at_half;
  logic             x1;

  always_comb begin
    cfg      = decode_frame(fmt_sel);
    last_idx = cfg.seven ? 3'd6 : 3'd7;
    x1       = 1'b0;
    unique case (div_sel)
      DIV_MID: begin
        div_m1  = CNT_W'(MID_DIV - 1);
        half_m1 = CNT_W'(MID_DIV / 2 - 1);
      end
      DIV_HI: begin
        div_m1  = CNT_W'(HI_DIV - 1);
        half_m1 = CNT_W'(HI_DIV / 2 - 1);
      end
      default: begin
        div_m1  = '0;
        half_m1 = '0;
        x1      = 1'b1;
      end
    endcase
    at_end  = (cnt == div_m1);
    at_half = (cnt == half_m1);
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      shr       <= '0;
      par_acc   <= 1'b0;
      fe_acc    <= 1'b0;
      stop_pend <= 1'b0;
    end else if (tick) begin
      unique case (state)
        ST_IDLE: begin
          cnt     <= '0;
          idx     <= '0;
          par_acc <= 1'b0;
          fe_acc  <= 1'b0;
          if (!rxd) state <= x1 ? ST_DATA : ST_START;
        end
        ST_START: begin
          if (at_half) begin
            cnt   <= '0;
            state <= rxd ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (at_end) begin
            cnt     <= '0;
            shr     <= {rxd, shr[7:1]};
            par_acc <= par_acc ^ rxd;
            if (idx == last_idx) begin
              state     <= cfg.par_en ? ST_PAR : ST_STOP;
              stop_pend <= cfg.two_stop;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_end) begin
            cnt     <= '0;
            par_acc <= par_acc ^ rxd;
            state   <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_end) begin
            cnt    <= '0;
            fe_acc <= fe_acc | ~rxd;
            if (stop_pend) stop_pend <= 1'b0;
            else           state     <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done   = tick & at_end & (state == ST_STOP) & ~stop_pend;
  assign byte_o = cfg.seven ? {1'b0, shr[7:1]} : shr;
  assign fe_o   = fe_acc | ~rxd;
  assign pe_o   = cfg.par_en & (par_acc ^ cfg.odd);

  // R3: the receiver only moves on a sample event
  a_r3_still_between_events: assert property (@(posedge clk) disable iff (hold)
    !tick |=> $stable(state) && $stable(cnt) && $stable(shr));

  // R4: a sub-bit counter never passes its bit length
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (hold)
    (state != ST_IDLE) |-> (cnt <= div_m1));

  // R4: x1 mode never uses the half-bit start check
  a_r4_no_start_wait_x1: assert property (@(posedge clk) disable iff (hold)
    (state == ST_IDLE && x1 && tick && !rxd) |=> (state == ST_DATA));
endmodule

// File: rtl/uwr_hold.sv
module uwr_hold (
  input  logic       clk,
  input  logic       hold,
  input  logic       done,
  input  logic [7:0] byte_i,
  input  logic       fe_i,
  input  logic       pe_i,
  input  logic       rd,
  output logic       valid,
  output logic [7:0] data,
  output logic       fe,
  output logic       pe,
  output logic       oe
);
  always_ff @(posedge clk) begin
    if (hold) begin
      valid <= 1'b0;
      data  <= '0;
      fe    <= 1'b0;
      pe    <= 1'b0;
      oe    <= 1'b0;
    end else if (done) begin
      valid <= 1'b1;
      data  <= byte_i;
      fe    <= fe_i;
      pe    <= pe_i;
      oe    <= valid & ~rd;
    end else if (rd) begin
      valid <= 1'b0;
      fe    <= 1'b0;
      pe    <= 1'b0;
      oe    <= 1'b0;
    end
  end

  // R9: a read with nothing arriving empties the holding stage
  a_r9_read_clears: assert property (@(posedge clk) disable iff (hold)
    (rd && !done) |=> !valid && !fe && !pe && !oe);

  // R8: an unread byte overwritten raises overrun
  a_r8_overrun_flag: assert property (@(posedge clk) disable iff (hold)
    (done && valid && !rd) |=> oe && valid);

  // R10: a completing character is presented the next cycle
  a_r10_load_next: assert property (@(posedge clk) disable iff (hold)
    done |=> valid && (data == $past(byte_i)));
endmodule

// File: rtl/uart_wordfmt_rx.sv
module uart_wordfmt_rx
  import uart_wordfmt_pkg::*;
#(
  parameter int MID_DIV     = 16,
  parameter int HI_DIV      = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] fmt_sel,
  input  logic [1:0] div_sel,
  input  logic       rx_clk,
  input  logic       rx_din,
  input  logic       rx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       err_frame,
  output logic       err_parity,
  output logic       err_overrun
);
  logic [1:0] sync_q;
  logic       tick;
  logic       hold;
  logic       done;
  logic [7:0] byte_w;
  logic       fe_w;
  logic       pe_w;

  assign hold = rst | (div_sel == DIV_HOLD);

  // bit 1: serial line (idles high), bit 0: baud clock
  uwr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rx_din, rx_clk}),
    .q   (sync_q)
  );

  uwr_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (sync_q[0]),
    .rise (tick)
  );

  uwr_deframe #(.MID_DIV(MID_DIV), .HI_DIV(HI_DIV)) u_deframe (
    .clk     (clk),
    .hold    (hold),
    .tick    (tick),
    .rxd     (sync_q[1]),
    .fmt_sel (fmt_sel),
    .div_sel (div_sel),
    .done    (done),
    .byte_o  (byte_w),
    .fe_o    (fe_w),
    .pe_o    (pe_w)
  );

  uwr_hold u_hold (
    .clk    (clk),
    .hold   (hold),
    .done   (done),
    .byte_i (byte_w),
    .fe_i   (fe_w),
    .pe_i   (pe_w),
    .rd     (rx_ready),
    .valid  (rx_valid),
    .data   (rx_data),
    .fe     (err_frame),
    .pe     (err_parity),
    .oe     (err_overrun)
  );

  // R1: reset or the hold code empties the outputs
  a_r1_hold_empties: assert property (@(posedge clk)
    hold |=> !rx_valid && !err_frame && !err_parity && !err_overrun && (rx_data == 8'h00));

  // R5: 7-bit formats present a zero top bit
  a_r5_top_bit_zero: assert property (@(posedge clk) disable iff (hold)
    (done && !fmt_sel[2]) |=> !rx_data[7]);

  // R6: parity-less formats never flag parity
  a_r6_no_parity_flag: assert property (@(posedge clk) disable iff (hold)
    (done && (fmt_sel == 3'd4 || fmt_sel == 3'd5)) |=> !err_parity);
endmodule

// File: tb/uart_wordfmt_rx_bench.sv
module uart_wordfmt_rx_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] fmt_sel = 3'd0;
  logic [1:0] div_sel = 2'd0;
  logic       rx_clk = 1'b0;
  logic       rx_din = 1'b1;
  logic       rx_ready = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       err_frame, err_parity, err_overrun;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_wordfmt_rx u_uart_wordfmt_rx (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .div_sel(div_sel),
    .rx_clk(rx_clk), .rx_din(rx_din), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .err_frame(err_frame),
    .err_parity(err_parity), .err_overrun(err_overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_c1, m_c2, m_cq, m_d1 = 1'b1, m_d2 = 1'b1;
  int m_phase = 0;   // 0 idle, 1 start check, 2 collecting
  int m_wait = 0;
  int m_slot = 0;
  bit m_bits[$];
  bit       m_valid = 0, m_fe = 0, m_pe = 0, m_oe = 0;
  bit [7:0] m_data = 0;

  function automatic int per_bit(input logic [1:0] d);
    return (d == 2'd1) ? 16 : (d == 2'd2) ? 64 : 1;
  endfunction
  function automatic int width_of(input int f);  return (f >= 4) ? 8 : 7; endfunction
  function automatic int has_par(input int f);   return (f == 4 || f == 5) ? 0 : 1; endfunction
  function automatic int stops_of(input int f);  return (f == 0 || f == 1 || f == 4) ? 2 : 1; endfunction

  always @(posedge clk) begin
    bit ev, lv, fin;
    bit [7:0] nb;
    bit nfe, npe;
    int f, n, ones, dv;
    ev = m_c2 && !m_cq;
    lv = m_d2;
    fin = 0;
    nb = 0; nfe = 0; npe = 0;
    f = int'(fmt_sel);
    dv = per_bit(div_sel);
    if (rst) begin
      m_c1 = 0; m_c2 = 0; m_cq = 0; m_d1 = 1; m_d2 = 1;
      m_phase = 0; m_valid = 0; m_data = 0; m_fe = 0; m_pe = 0; m_oe = 0;
    end else begin
      if (div_sel == 2'd3) begin
        m_phase = 0; m_valid = 0; m_data = 0; m_fe = 0; m_pe = 0; m_oe = 0;
      end else begin
        if (ev) begin
          if (m_phase == 0) begin
            if (!lv) begin
              m_wait = 0; m_slot = 0; m_bits.delete();
              m_phase = (dv == 1) ? 2 : 1;
            end
          end else if (m_phase == 1) begin
            m_wait++;
            if (m_wait == dv / 2) begin
              m_wait = 0;
              m_phase = lv ? 0 : 2;
            end
          end else begin
            m_wait++;
            if (m_wait == dv) begin
              m_wait = 0;
              m_bits.push_back(lv);
              n = width_of(f) + has_par(f) + stops_of(f);
              if (m_bits.size() == n) begin
                fin = 1; m_phase = 0; ones = 0;
                for (int i = 0; i < width_of(f); i++) begin
                  nb[i] = m_bits[i];
                  ones += int'(m_bits[i]);
                end
                if (has_par(f) == 1) begin
                  ones += int'(m_bits[width_of(f)]);
                  npe = ((ones % 2) == 1) ^ (f % 2 == 1);
                end
                for (int i = width_of(f) + has_par(f); i < n; i++)
                  if (!m_bits[i]) nfe = 1;
              end
            end
          end
        end
        if (fin) begin
          m_oe = m_valid && !rx_ready;
          m_valid = 1; m_data = nb; m_fe = nfe; m_pe = npe;
        end else if (rx_ready) begin
          m_valid = 0; m_fe = 0; m_pe = 0; m_oe = 0;
        end
      end
      m_cq = m_c2; m_c2 = m_c1; m_c1 = rx_clk;
      m_d2 = m_d1; m_d1 = rx_din;
    end
  end

  // R10: every output against the model, every cycle
  always @(negedge clk) begin
    cycles++;
    chk(rx_valid == m_valid && rx_data == m_data && err_frame == m_fe &&
        err_parity == m_pe && err_overrun == m_oe, "R10", "per-cycle outputs",
        {rx_valid, err_frame, err_parity, err_overrun, rx_data},
        {m_valid, m_fe, m_pe, m_oe, m_data});
    if (cycles > 150000) begin
      chk(0, "R10", "watchdog expired", cycles, 150000);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic rx_period();
    rx_clk = 1'b0;
    repeat (2) @(negedge clk);
    rx_clk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic drive_bit(input bit v, input int periods);
    rx_din = v;
    for (int k = 0; k < periods; k++) rx_period();
  endtask

  task automatic send_frame(input bit [7:0] b, input int f, input bit flip_par,
                            input bit bad_stop);
    int d;
    bit p;
    d = per_bit(div_sel);
    drive_bit(1'b0, d);
    p = 0;
    for (int i = 0; i < width_of(f); i++) begin
      drive_bit(b[i], d);
      p ^= b[i];
    end
    if (has_par(f) == 1) drive_bit(p ^ (f % 2 == 1) ^ flip_par, d);
    for (int s = 0; s < stops_of(f); s++) drive_bit((s == 0) ? !bad_stop : 1'b1, d);
    drive_bit(1'b1, 2);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_held(input string req, input bit [7:0] d, input bit fe,
                             input bit pe, input bit oe);
    chk(rx_valid == 1'b1, req, "valid", rx_valid, 1);
    chk(rx_data == d, req, "data", rx_data, d);
    chk({err_frame, err_parity, err_overrun} == {fe, pe, oe}, req, "flags fe/pe/oe",
        {err_frame, err_parity, err_overrun}, {fe, pe, oe});
  endtask

  task automatic read_once();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    bit [7:0] b;
    repeat (4) @(negedge clk);
    chk(!rx_valid && rx_data == 0 && !err_frame && !err_parity && !err_overrun,
        "R1", "reset state", {rx_valid, rx_data}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2 R5: every format in x1 mode
    div_sel = 2'd0;
    for (int f = 0; f < 8; f++) begin
      fmt_sel = 3'(f);
      b = 8'h35 + 8'(f * 8'h29);
      send_frame(b, f, 1'b0, 1'b0);
      expect_held("R2", (f < 4) ? (b & 8'h7F) : b, 0, 0, 0);
      read_once();
      chk(!rx_valid, "R9", "valid after read", rx_valid, 0);
    end

    // R5: top bit cleared for 7-bit
    fmt_sel = 3'd2;
    send_frame(8'hFF, 2, 1'b0, 1'b0);
    expect_held("R5", 8'h7F, 0, 0, 0);
    read_once();

    // R3: x16 and x64 sampling
    div_sel = 2'd1;
    fmt_sel = 3'd6;
    send_frame(8'hC3, 6, 1'b0, 1'b0);
    expect_held("R3", 8'hC3, 0, 0, 0);
    read_once();
    fmt_sel = 3'd1;
    send_frame(8'h4E, 1, 1'b0, 1'b0);
    expect_held("R3", 8'h4E, 0, 0, 0);
    read_once();
    div_sel = 2'd2;
    fmt_sel = 3'd5;
    send_frame(8'h96, 5, 1'b0, 1'b0);
    expect_held("R3", 8'h96, 0, 0, 0);
    read_once();

    // R4: short glitch is abandoned in x16
    div_sel = 2'd1;
    fmt_sel = 3'd7;
    drive_bit(1'b0, 3);
    drive_bit(1'b1, 24);
    chk(!rx_valid, "R4", "glitch gave no byte", rx_valid, 0);
    send_frame(8'h5A, 7, 1'b0, 1'b0);
    expect_held("R4", 8'h5A, 0, 0, 0);
    read_once();

    // R6: parity error, x1 and x16
    send_frame(8'h21, 7, 1'b1, 1'b0);
    expect_held("R6", 8'h21, 0, 1, 0);
    read_once();
    div_sel = 2'd0;
    fmt_sel = 3'd0;
    send_frame(8'h13, 0, 1'b1, 1'b0);
    expect_held("R6", 8'h13, 0, 1, 0);
    read_once();

    // R7: framing error, x1 and x16
    fmt_sel = 3'd5;
    send_frame(8'hE7, 5, 1'b0, 1'b1);
    expect_held("R7", 8'hE7, 1, 0, 0);
    read_once();
    div_sel = 2'd1;
    fmt_sel = 3'd3;
    send_frame(8'h3C, 3, 1'b0, 1'b1);
    expect_held("R7", 8'h3C, 1, 0, 0);
    read_once();
    chk(!err_frame && !rx_valid, "R9", "flags cleared by read", err_frame, 0);

    // R8: overrun, new byte replaces old
    div_sel = 2'd0;
    fmt_sel = 3'd6;
    send_frame(8'h11, 6, 1'b0, 1'b0);
    send_frame(8'h22, 6, 1'b0, 1'b0);
    expect_held("R8", 8'h22, 0, 0, 1);
    read_once();
    chk(!err_overrun, "R9", "overrun cleared by read", err_overrun, 0);

    // R1: hold code clears pending byte and flags
    send_frame(8'h77, 6, 1'b1, 1'b0);
    expect_held("R1", 8'h77, 0, 1, 0);
    div_sel = 2'd3;
    repeat (2) @(negedge clk);
    chk(!rx_valid && !err_parity && rx_data == 0, "R1", "hold code clears",
        {rx_valid, err_parity, rx_data}, 0);
    div_sel = 2'd0;
    repeat (4) @(negedge clk);
    send_frame(8'h80, 6, 1'b0, 1'b0);
    expect_held("R1", 8'h80, 0, 0, 0);
    read_once();

    finish_run();
  end
endmodule